// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Port

This block models the synchronous front end of a double-data-rate static RAM that moves four words per access. It runs from one clock at twice the command rate. An internal phase bit splits the rising edges into K edges and K-bar edges, and the `kedge_next` output tells the surrounding logic which kind of edge comes next. A command is sampled only on a K edge. Once a command is taken, the next K edge is skipped, so a burst of four beats fills two command cycles. Write beats are taken on the four edges that follow the command, with per-lane write enables applied to each beat. Read beats leave an output register on four consecutive edges, together with an output enable and a complementary strobe pair that toggles with every beat.

The read latency input selects where the first beat appears: one command cycle after the command edge, or one and a half. A parameter selects how a burst starts. In one variant every burst starts at word 0 and the whole address selects the row. In the other, the two low address bits give the start word and the count wraps within the row. When a read is accepted, the whole row is copied, and the write beat landing on that same edge is merged into the copy. A read therefore returns data that is current at its command edge and is not disturbed by writes issued after it.

Top module: `burst4_ddr_sram`

## Requirements
- R1: `kedge_next` is high during reset and alternates on every `clk` rising edge afterwards. An edge is a K edge exactly when `kedge_next` was high before it.
- R2: A command is accepted on a K edge when `cmd_n` is low, unless a command was accepted on the previous K edge. A command seen on that skipped K edge, or any edge with `cmd_n` high, starts nothing: no write reaches the array and no read beat appears.
- R3: A write (`rd_sel` low) captures `wdata` on the four edges that follow the command edge. It stores beat b at word (start + b) mod 4 of the addressed row.
- R4: On each write beat, lane i (`wdata[i*LANE_W +: LANE_W]`) is stored only when `lane_wen_n[i]` is low. Masked lanes keep their old contents.
- R5: With START_FROM_ADDR = 1, the start word is `addr[1:0]` and the row is the bits above them, with wrap from word 3 to word 0. With START_FROM_ADDR = 0, the start word is always 0 and all of `addr` selects the row.
- R6: With `lat_long` low, the first read beat is registered on the second edge after the command edge. With `lat_long` high, it is registered on the third. `lat_long` changes only while no read is pending.
- R7: A read (`rd_sel` high) drives words start, start+1, start+2, start+3 (mod 4) of one row on four consecutive edges.
- R8: `rdata_oe` is high exactly while a read beat is on `rdata` and low otherwise, including during reset.
- R9: `strobe_p` toggles on every edge that registers a read beat and holds otherwise, and `strobe_n` is always its complement. Both reset to `strobe_p` = 0.
- R10: A read accepted on the edge where a write's last beat lands returns that beat. A write accepted after a read does not change the words that read returns.
- R11: Reads accepted on successive command slots produce an unbroken beat stream with `rdata_oe` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; edges alternate between K and K-bar |
| rst_n | input | 1 | Active-low synchronous reset |
| kedge_next | output | 1 | High when the next rising edge is a K edge |
| cmd_n | input | 1 | Active-low command strobe, sampled on K edges |
| rd_sel | input | 1 | 1 = read burst, 0 = write burst |
| addr | input | ROW_W + 2*START_FROM_ADDR | Row address, plus start word when enabled |
| lane_wen_n | input | LANES | Active-low per-lane write enables, sampled per beat |
| wdata | input | DATA_W | Write beat data |
| lat_long | input | 1 | 0 = one-cycle read latency, 1 = one-and-a-half |
| rdata | output | DATA_W | Registered read beat |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |
| strobe_p | output | 1 | Echo strobe, toggles per read beat |
| strobe_n | output | 1 | Complement of `strobe_p` |

## Verification
The bench runs both burst-start variants side by side and chooses start offsets that force the row wrap. A design that ignored the offset, or that let the count leave the row, would return words from the wrong position. A read is placed on the same edge as the last beat of a write to the same row, and a write to a row is placed right after a read of it. A design without the merge would return stale data in the first case, and a design that read the array at beat time would return the new data in the second. Commands are also placed on the skipped K edge. If the skip were dropped, they would produce extra beats or overwrite a row that must stay unchanged. Both latency settings and masked lanes are run as well, so an off-by-one edge or a lane written against its enable shows up as a beat in the wrong cycle or a wrong word.

// File: rtl/burst4_ddr_sram.sv
module burst4_ddr_sram #(
  parameter int DATA_W = 16,
  parameter int LANES = 2,
  parameter int ROW_W = 4,
  parameter bit START_FROM_ADDR = 1'b1,
  localparam int ADDR_W = ROW_W + (START_FROM_ADDR ? 2 : 0)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              kedge_next,
  input  logic              cmd_n,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wen_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lat_long,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              strobe_p,
  output logic              strobe_n
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int ROWS = 1 << ROW_W;

  logic ph, skip;
  logic [DATA_W-1:0] mem [ROWS][4];

  logic [2:0] wcnt;
  logic [ROW_W-1:0] wrow;
  logic [1:0] wstart;

  logic pend;
  logic [1:0] pdly, pstart;
  logic [DATA_W-1:0] pbuf [4];

  logic [DATA_W-1:0] obuf [4];
  logic [1:0] ostart, onext, oleft;
  logic [DATA_W-1:0] q_r;
  logic oe_r, stb_r;

  logic [DATA_W-1:0] view [4];
  logic [1:0] astart;

  wire k_edge = ~ph;
  wire accept = k_edge & ~skip & ~cmd_n;
  wire [ROW_W-1:0] arow = addr[ADDR_W-1 -: ROW_W];
  wire wbeat = (wcnt != 3'd0);
  wire [1:0] wword = wstart + 2'(wcnt - 3'd1);
  wire launch = pend && (pdly == 2'd1);

  if (START_FROM_ADDR) begin : g_offset
    assign astart = addr[1:0];
  end else begin : g_zero
    assign astart = 2'd0;
  end

  always_comb begin
    for (int w = 0; w < 4; w++) begin
      view[w] = mem[arow][w];
      for (int l = 0; l < LANES; l++)
        if (wbeat && wrow == arow && wword == 2'(w) && !lane_wen_n[l])
          view[w][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (wbeat)
      for (int l = 0; l < LANES; l++)
        if (!lane_wen_n[l])
          mem[wrow][wword][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (accept && rd_sel)
      for (int w = 0; w < 4; w++) pbuf[w] <= view[w];
    if (launch)
      for (int w = 0; w < 4; w++) obuf[w] <= pbuf[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0;
      skip <= 1'b0;
      wcnt <= '0;
      wrow <= '0;
      wstart <= '0;
      pend <= 1'b0;
      pdly <= '0;
      pstart <= '0;
      ostart <= '0;
      onext <= '0;
      oleft <= '0;
      q_r <= '0;
      oe_r <= 1'b0;
      stb_r <= 1'b0;
    end else begin
      ph <= ~ph;
      if (k_edge) skip <= accept;

      if (wbeat) wcnt <= (wcnt == 3'd4) ? 3'd0 : wcnt + 3'd1;
      if (accept && !rd_sel) begin
        wcnt <= 3'd1;
        wrow <= arow;
        wstart <= astart;
      end

      if (pend) begin
        if (pdly == 2'd1) pend <= 1'b0;
        pdly <= pdly - 2'd1;
      end
      if (accept && rd_sel) begin
        pend <= 1'b1;
        pdly <= lat_long ? 2'd3 : 2'd2;
        pstart <= astart;
      end

      if (launch) begin
        q_r <= pbuf[pstart];
        oe_r <= 1'b1;
        stb_r <= ~stb_r;
        ostart <= pstart;
        onext <= 2'd1;
        oleft <= 2'd3;
      end else if (oleft != 2'd0) begin
        q_r <= obuf[ostart + onext];
        stb_r <= ~stb_r;
        onext <= onext + 2'd1;
        oleft <= oleft - 2'd1;
      end else begin
        oe_r <= 1'b0;
      end
    end
  end

  assign kedge_next = ~ph;
  assign rdata = q_r;
  assign rdata_oe = oe_r;
  assign strobe_p = stb_r;
  assign strobe_n = ~stb_r;
endmodule

// File: rtl/burst4_ddr_sram_chk.sv
module burst4_ddr_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_n,
  input logic rd_sel,
  input logic lat_long,
  input logic kedge_next,
  input logic rdata_oe,
  input logic strobe_p,
  input logic strobe_n
);
  logic [2:0] up;
  logic [3:0] since_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= '0;
      since_rd <= 4'd15;
    end else begin
      if (up != 3'd7) up <= up + 3'd1;
      if (!cmd_n && rd_sel && kedge_next) since_rd <= '0;
      else if (since_rd != 4'd15) since_rd <= since_rd + 4'd1;
    end
  end

  a_r1_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (up != 3'd0) |-> (kedge_next != $past(kedge_next)));

  a_r9_strobe_per_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (up != 3'd0 && rdata_oe) |-> (strobe_p != $past(strobe_p)));

  a_r9_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (up != 3'd0 && !rdata_oe) |-> $stable(strobe_p));

  a_r9_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n != strobe_p);

  a_r6_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 3'd4 && $rose(rdata_oe) && !lat_long) |-> $past(!cmd_n && rd_sel && kedge_next, 3));

  a_r6_long_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 3'd4 && $rose(rdata_oe) && lat_long) |-> $past(!cmd_n && rd_sel && kedge_next, 4));

  a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (since_rd <= 4'd7));
endmodule

bind burst4_ddr_sram burst4_ddr_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .rd_sel(rd_sel), .lat_long(lat_long),
  .kedge_next(kedge_next), .rdata_oe(rdata_oe), .strobe_p(strobe_p), .strobe_n(strobe_n)
);

// File: tb/sim_burst4_ddr_sram.sv
`timescale 1ns/1ps
module sim_burst4_ddr_sram;
  localparam int DW = 16;
  localparam int LN = 2;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_n = 1'b1;
  logic rd_sel = 1'b0;
  logic [RW+1:0] addr = '0;
  logic [LN-1:0] lane_wen_n = '1;
  logic [DW-1:0] wdata = '0;
  logic lat_long = 1'b0;

  logic kp0, oe0, sp0, sn0, kp1, oe1, sp1, sn1;
  logic [DW-1:0] q0, q1;

  burst4_ddr_sram #(.DATA_W(DW), .LANES(LN), .ROW_W(RW), .START_FROM_ADDR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .kedge_next(kp0), .cmd_n(cmd_n), .rd_sel(rd_sel),
    .addr(addr), .lane_wen_n(lane_wen_n), .wdata(wdata), .lat_long(lat_long),
    .rdata(q0), .rdata_oe(oe0), .strobe_p(sp0), .strobe_n(sn0));

  burst4_ddr_sram #(.DATA_W(DW), .LANES(LN), .ROW_W(RW), .START_FROM_ADDR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .kedge_next(kp1), .cmd_n(cmd_n), .rd_sel(rd_sel),
    .addr(addr[RW+1:2]), .lane_wen_n(lane_wen_n), .wdata(wdata), .lat_long(lat_long),
    .rdata(q1), .rdata_oe(oe1), .strobe_p(sp1), .strobe_n(sn1));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit run = 1'b0;
  logic prev_sp = 1'b0;

  logic [DW-1:0] m0 [64];
  logic [DW-1:0] m1 [64];

  typedef struct {
    int due;
    logic [DW-1:0] v0;
    logic [DW-1:0] v1;
    string tag;
  } exp_t;
  exp_t sq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: pops expected beats at their due cycle
  always @(negedge clk) begin
    if (run) begin
      while (sq.size() > 0 && sq[0].due < cyc) begin
        exp_t m;
        m = sq.pop_front();
        chk(1'b0, {m.tag, " R6 beat missed"}, 64'(cyc), 64'(m.due));
      end
      if (sq.size() > 0 && sq[0].due == cyc) begin
        exp_t e;
        e = sq.pop_front();
        chk(oe0 === 1'b1 && oe1 === 1'b1, {e.tag, " R6 R8 oe at beat"}, {62'd0, oe1, oe0}, 64'd3);
        chk(q0 === e.v0, {e.tag, " R7 word (offset variant)"}, 64'(q0), 64'(e.v0));
        chk(q1 === e.v1, {e.tag, " R5 word (start-zero variant)"}, 64'(q1), 64'(e.v1));
        chk(sp0 !== prev_sp, "R9 strobe toggles on beat", 64'(sp0), 64'(~prev_sp));
        chk(sn0 === ~sp0, "R9 strobe pair", 64'(sn0), 64'(~sp0));
      end else begin
        chk(oe0 === 1'b0 && oe1 === 1'b0, "R2 R8 bus idle", {62'd0, oe1, oe0}, 64'd0);
        chk(sp0 === prev_sp, "R9 strobe holds", 64'(sp0), 64'(prev_sp));
      end
      prev_sp = sp0;
    end
  end

  task automatic align();
    if (kp0 !== 1'b1) @(negedge clk);
  endtask

  task automatic wr(input int row, input int st, input logic [63:0] wv, input logic [7:0] bm);
    align();
    cmd_n = 1'b0; rd_sel = 1'b0; addr = {4'(row), 2'(st)};
    @(negedge clk);
    cmd_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      wdata = wv[b*16 +: 16];
      lane_wen_n = bm[b*2 +: 2];
      for (int l = 0; l < LN; l++)
        if (!bm[b*2 + l]) begin
          m0[row*4 + ((st + b) % 4)][l*8 +: 8] = wv[b*16 + l*8 +: 8];
          m1[row*4 + b][l*8 +: 8] = wv[b*16 + l*8 +: 8];
        end
      if (b < 3) @(negedge clk);
    end
  endtask

  task automatic issue_read(input int row, input int st, input string tag);
    int lat;
    lat = lat_long ? 3 : 2;
    cmd_n = 1'b0; rd_sel = 1'b1; addr = {4'(row), 2'(st)};
    for (int b = 0; b < 4; b++) begin
      exp_t e;
      e.due = cyc + 1 + lat + b;
      e.v0 = m0[row*4 + ((st + b) % 4)];
      e.v1 = m1[row*4 + b];
      e.tag = tag;
      sq.push_back(e);
    end
  endtask

  task automatic rd(input int row, input int st, input string tag);
    align();
    issue_read(row, st, tag);
    @(negedge clk);
    cmd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // read, then a command on the skipped K edge (must be ignored)
  task automatic rd_ghost(input int row, input int grow, input bit ghost_write);
    align();
    issue_read(row, 0, "R2 ghost");
    @(negedge clk);
    cmd_n = 1'b1;
    @(negedge clk);
    cmd_n = 1'b0; rd_sel = !ghost_write; addr = {4'(grow), 2'd0};
    wdata = 16'hDEAD; lane_wen_n = '0;
    @(negedge clk);
    cmd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int kcycles);
    align();
    cmd_n = 1'b1;
    repeat (2 * kcycles) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual cycles=%0d expected completion before %0d", cyc, 100000);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(kp0 === 1'b1, "R1 reset phase", 64'(kp0), 64'd1);
    chk(oe0 === 1'b0 && oe1 === 1'b0, "R8 reset oe", {62'd0, oe1, oe0}, 64'd0);
    chk(sp0 === 1'b0 && sn0 === 1'b1, "R9 reset strobe", {62'd0, sn0, sp0}, 64'd2);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(kp0 === 1'(i % 2), "R1 phase alternates", 64'(kp0), 64'(i % 2));
    end
    run = 1'b1;

    // fill every row with unique words (R3)
    for (int r = 0; r < 16; r++)
      wr(r, 0, {16'(r*256 + 16'h34), 16'(r*256 + 16'h23), 16'(r*256 + 16'h12), 16'(r*256 + 16'h01)}, 8'h00);
    idle(1);

    // short latency, offsets with wrap, back-to-back stream (R5 R6 R7 R11)
    rd(3, 0, "R7 start0");
    rd(3, 2, "R5 wrap");
    rd(5, 1, "R11 stream");
    rd(6, 3, "R11 stream");

    // masked lanes then immediate read of same row (R4 R10)
    wr(7, 1, 64'hA4A4_B3B3_C2C2_D1D1, {2'b11, 2'b10, 2'b01, 2'b00});
    rd(7, 1, "R10 forward");
    rd(7, 0, "R4 masked lanes");

    // commands on the skipped K edge do nothing (R2)
    rd_ghost(2, 9, 1'b0);
    rd_ghost(4, 10, 1'b1);
    idle(3);
    rd(10, 0, "R2 ghost write absent");

    // read then write of the same row: read keeps old data (R10)
    rd(11, 2, "R10 read before write");
    wr(11, 0, 64'h1111_2222_3333_4444, 8'h00);
    rd(11, 0, "R10 new data");
    idle(4);

    // long latency (R6)
    lat_long = 1'b1;
    idle(1);
    rd(3, 1, "R6 long");
    rd(7, 3, "R6 long");
    wr(12, 2, 64'h5A5A_6B6B_7C7C_8D8D, {2'b00, 2'b01, 2'b00, 2'b10});
    rd(12, 2, "R10 long forward");
    rd(12, 0, "R4 long masked");
    idle(6);

    chk(sq.size() == 0, "R7 all beats seen", 64'(sq.size()), 64'd0);
    summary();
  end
endmodule